// File: doc/BRIEF.md
# Chained Counter Watchdog Timer

A two-counter timer unit on a small 32-bit register bus. Each counter has a 64-bit reload value, an enable, a mode, a trigger source and a clock divider. Counter 0 runs as a one-shot. When it is enabled with a reload of zero, it finishes at once and sends out an end-of-count pulse. Counter 1 is armed in trigger mode with counter 0 as its source. Each end pulse from counter 0 reloads counter 1 and starts it counting down again.

Software starts the watchdog and refreshes it in the same way: it disables and then re-enables counter 0. No separate refresh register exists. Counter 1 can be nominated as the system watchdog through a selection register. When a nominated counter 1 runs out, the block raises a reset output. The output stays raised until software disables counter 1.

Top module: `chain_wdt`

## Requirements
- R1: Counter k (k = 0, 1) has a control word at byte address 0x10·k, the low reload word at 0x10·k+4 and the high reload word at 0x10·k+8. Reading a reload word returns the last value written to it, whether or not a load has happened since. Unmapped addresses read zero.
- R2: The control word fields are: bit 0 enable; bit 1 active (read-only, and any value written to it is ignored); bits [3:2] mode; bits [7:4] trigger source; bits [15:8] divider. Bits [31:16] read zero.
- R3: A running counter loaded with N ≥ 1 decrements once every P clocks, where P is the divider field, or 2 if that field is below 2. Counter 1 reaches zero on the N·P-th clock edge after its load edge. A trigger from counter 0's end pulse lands one edge after the enable write, so the reset output rises N·P+1 edges after that write.
- R4: In any mode other than 11, a control write that sets enable while the counter is disabled loads the reload value and sets active. When the count reaches zero, active clears and a single-cycle end pulse is produced.
- R5: If the reload value is zero when such a load happens, the counter sets no active state. It produces its end pulse in the cycle right after the load edge.
- R6: Counter 1 in mode 11 with trigger source 5 reloads and restarts on each end pulse of counter 0, including while it is already counting. Each refresh therefore pushes expiry out to a full N·P from the new load.
- R7: Counter 1 ignores a trigger pulse while it is disabled. In mode 11, setting enable does not start it.
- R8: In mode 11 with any trigger source other than 5, counter 1 is never triggered.
- R9: The selection register at 0x40 keeps only bit 1, which nominates counter 1 as watchdog, and reads back in that position. With bit 1 clear, the expiry of counter 1 leaves the reset output low.
- R10: A nominated counter 1 reaching zero sets the reset output. The output stays set, even if the selection is cleared, until a control write to counter 1 clears its enable bit.
- R11: A write to a reload word does not change a count already in progress. The new value is used from the next load.
- R12: A nominated counter 1 with a zero reload raises the reset output on the same edge as the trigger that loads it.
- R13: After reset, every register reads zero and the reset output is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; counters and the divider run on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | AW | Byte address for writes and reads |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address, combinational |
| wdt_rst | output | 1 | Watchdog reset request, held until counter 1 is disabled |

## Verification
Errors in the divider, the reload or the trigger path all show up as a wrong edge for the first rise of the reset output. The bench times that rise to the exact edge across a sweep of dividers and reload values. A lost refresh shows as a rise one refresh window too early. A spurious trigger shows as a rise, or as a set active bit, where the count should have stayed idle. Errors in the register bank show on the first read of each field.

// File: rtl/chain_wdt.sv
module chain_wdt #(
  parameter int AW = 8,
  parameter int SEL_ADDR = 'h40,
  parameter int TRIG_PREV = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          wdt_rst
);
  localparam int CW = 64;
  localparam int NC = 2;
  localparam logic [1:0] HWTRIG = 2'b11;

  logic [NC-1:0] en, act, eoc;
  logic [1:0]    mode [NC];
  logic [3:0]    src  [NC];
  logic [7:0]    pre  [NC];
  logic [7:0]    pc   [NC];
  logic [CW-1:0] rld  [NC];
  logic [CW-1:0] cnt  [NC];
  logic          wd_sel;

  logic [NC-1:0] wctl, wlo, whi, dis, start, trig, load, tick, endev;
  logic [7:0]    pe [NC];

  always_comb begin
    for (int i = 0; i < NC; i++) begin
      wctl[i]  = bus_wr && (bus_addr == AW'(16*i));
      wlo[i]   = bus_wr && (bus_addr == AW'(16*i + 4));
      whi[i]   = bus_wr && (bus_addr == AW'(16*i + 8));
      dis[i]   = wctl[i] && !bus_wdata[0];
      start[i] = wctl[i] && bus_wdata[0] && !en[i] && (bus_wdata[3:2] != HWTRIG);
      pe[i]    = (pre[i] < 8'd2) ? 8'd2 : pre[i];
      tick[i]  = act[i] && en[i] && (pc[i] == pe[i] - 8'd1);
    end
    trig[0] = 1'b0;
    trig[1] = en[1] && (mode[1] == HWTRIG) && (src[1] == 4'(TRIG_PREV)) && eoc[0];
    for (int i = 0; i < NC; i++) begin
      load[i]  = (start[i] || trig[i]) && !dis[i];
      endev[i] = (load[i] && rld[i] == '0) ||
                 (!load[i] && !dis[i] && tick[i] && cnt[i] == CW'(1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en <= '0; act <= '0; eoc <= '0; wd_sel <= 1'b0; wdt_rst <= 1'b0;
      for (int i = 0; i < NC; i++) begin
        mode[i] <= '0; src[i] <= '0; pre[i] <= '0; pc[i] <= '0;
        rld[i] <= '0; cnt[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NC; i++) begin
        if (wctl[i]) begin
          en[i]   <= bus_wdata[0];
          mode[i] <= bus_wdata[3:2];
          src[i]  <= bus_wdata[7:4];
          pre[i]  <= bus_wdata[15:8];
        end
        if (wlo[i]) rld[i][31:0]  <= bus_wdata;
        if (whi[i]) rld[i][63:32] <= bus_wdata;
        eoc[i] <= endev[i];
        if (dis[i]) begin
          act[i] <= 1'b0;
        end else if (load[i]) begin
          cnt[i] <= rld[i];
          pc[i]  <= '0;
          act[i] <= (rld[i] != '0);
        end else if (act[i]) begin
          if (tick[i]) begin
            pc[i]  <= '0;
            cnt[i] <= cnt[i] - CW'(1);
            if (cnt[i] == CW'(1)) act[i] <= 1'b0;
          end else begin
            pc[i] <= pc[i] + 8'd1;
          end
        end
      end
      if (bus_wr && bus_addr == AW'(SEL_ADDR)) wd_sel <= bus_wdata[1];
      if (dis[1]) wdt_rst <= 1'b0;
      else if (endev[1] && wd_sel) wdt_rst <= 1'b1;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == AW'(SEL_ADDR)) bus_rdata = {30'd0, wd_sel, 1'b0};
    for (int i = 0; i < NC; i++) begin
      if (bus_addr == AW'(16*i))     bus_rdata = {16'd0, pre[i], src[i], mode[i], act[i], en[i]};
      if (bus_addr == AW'(16*i + 4)) bus_rdata = rld[i][31:0];
      if (bus_addr == AW'(16*i + 8)) bus_rdata = rld[i][63:32];
    end
  end
endmodule

module chain_wdt_chk #(parameter int AW = 8) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_wr,
  input logic [AW-1:0] bus_addr,
  input logic [31:0]   bus_wdata,
  input logic [1:0]    en,
  input logic [1:0]    act,
  input logic [1:0]    eoc,
  input logic          wd_sel,
  input logic          wdt_rst
);
  // R9
  rise_needs_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wdt_rst) |-> $past(wd_sel));
  // R10
  release_on_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == AW'('h10) && !bus_wdata[0]) |=> !wdt_rst);
  // R5
  end_pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eoc[0] |=> !eoc[0]);
  // R4
  end_clears_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eoc[1] |-> !act[1]);
  // R7
  idle_stays_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en[1] && !(bus_wr && bus_addr == AW'('h10))) |=> !act[1]);
endmodule

bind chain_wdt chain_wdt_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .en(en), .act(act), .eoc(eoc),
  .wd_sel(wd_sel), .wdt_rst(wdt_rst)
);

// File: tb/chain_wdt_bench.sv
module chain_wdt_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0, bus_wr = 0;
  logic [7:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0;
  wire  [31:0] bus_rdata;
  wire         wdt_rst;
  int errs = 0, checks = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  chain_wdt u_chain_wdt (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wdt_rst(wdt_rst)
  );

  task automatic chk(string req, logic [63:0] actual, logic [63:0] expect_v);
    checks++;
    if (actual !== expect_v) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, actual, expect_v);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic kick();
    wr(8'h00, 32'h0000_0200);
    wr(8'h00, 32'h0000_0201);
  endtask

  task automatic measure(int limit, output int k);
    k = 0;
    for (int j = 1; j <= limit; j++) begin
      @(negedge clk);
      if (wdt_rst === 1'b1) begin k = j; break; end
    end
  endtask

  task automatic setup(int n, int p, int s, bit sel);
    wr(8'h10, 32'h0);
    wr(8'h14, 32'(n));
    wr(8'h18, 32'h0);
    wr(8'h10, {16'h0, 8'(p), 4'(s), 2'b11, 2'b01});
    wr(8'h40, sel ? 32'h2 : 32'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int k;
    int pv[6] = '{0, 1, 2, 3, 4, 7};
    int nv[5] = '{1, 2, 3, 5, 8};
    repeat (3) @(negedge clk);
    rd(8'h00, d); chk("R13 ctrl0", d, 0);
    rd(8'h14, d); chk("R13 reload1", d, 0);
    rd(8'h40, d); chk("R13 sel", d, 0);
    chk("R13 wdt_rst", wdt_rst, 0);
    rst_n = 1;
    @(negedge clk);

    // R1 R2 register bank
    wr(8'h00, 32'hABCD_12F6); rd(8'h00, d); chk("R2 ctrl fields", d, 32'h0000_12F4);
    wr(8'h04, 32'hDEAD_BEEF); rd(8'h04, d); chk("R1 low word", d, 32'hDEAD_BEEF);
    wr(8'h18, 32'h1234_5678); rd(8'h18, d); chk("R1 high word", d, 32'h1234_5678);
    rd(8'h30, d); chk("R1 unmapped", d, 0);
    wr(8'h40, 32'hFFFF_FFFF); rd(8'h40, d); chk("R9 sel keeps bit1", d, 32'h2);
    wr(8'h40, 32'h0); rd(8'h40, d); chk("R9 sel cleared", d, 0);
    wr(8'h00, 0); wr(8'h04, 0); wr(8'h18, 0);

    // R4 one-shot counter 0 chained into counter 1
    setup(2, 2, 5, 1);
    wr(8'h04, 3); wr(8'h00, 0); wr(8'h00, 32'h0301);
    repeat (8) @(negedge clk);
    rd(8'h00, d); chk("R4 active while counting", d, 32'h0303);
    @(negedge clk);
    rd(8'h00, d); chk("R4 active clears at end", d, 32'h0301);
    measure(10, k); chk("R4 end pulse triggers counter1", k, 5);
    wr(8'h04, 0);

    // R3 sweep over divider and reload
    foreach (pv[a]) foreach (nv[b]) begin
      int pe;
      pe = (pv[a] < 2) ? 2 : pv[a];
      setup(nv[b], pv[a], 5, 1);
      kick();
      measure(1 + nv[b]*pe + 4, k);
      chk($sformatf("R3 expiry p=%0d n=%0d", pv[a], nv[b]), k, 1 + nv[b]*pe);
    end

    // R12 zero reload on counter 1, R5 immediate kick
    setup(0, 2, 5, 1); kick(); measure(5, k); chk("R12 zero reload", k, 1);

    // R9 not nominated
    setup(2, 2, 5, 0); kick(); measure(10, k); chk("R9 no reset without sel", k, 0);
    rd(8'h10, d); chk("R9 counter1 expired", d[1], 0);

    // R8 wrong trigger source
    setup(1, 2, 4, 1); kick(); measure(10, k); chk("R8 other source ignored", k, 0);
    rd(8'h10, d); chk("R8 counter1 idle", d[1], 0);

    // R7 trigger while disabled, enable without trigger
    setup(1, 2, 5, 1); wr(8'h10, 32'h025C); kick();
    repeat (3) @(negedge clk);
    rd(8'h10, d); chk("R7 disabled ignores trigger", d[1], 0);
    wr(8'h10, 32'h025D); measure(20, k); chk("R7 enable does not start", k, 0);

    // R6 refresh restarts count
    setup(4, 2, 5, 1); kick();
    repeat (5) @(negedge clk);
    kick(); measure(12, k); chk("R6 refresh extends", k, 9);

    // R11 reload write during count
    setup(3, 2, 5, 1); kick(); wr(8'h14, 50);
    measure(10, k); chk("R11 running count unchanged", k, 6);
    rd(8'h14, d); chk("R11 reload readback", d, 50);
    wr(8'h10, 32'h025C); wr(8'h10, 32'h025D); kick();
    measure(110, k); chk("R11 new value on next load", k, 101);

    // R10 latch and release
    wr(8'h40, 0); chk("R10 held after sel cleared", wdt_rst, 1);
    @(negedge clk); chk("R10 still held", wdt_rst, 1);
    wr(8'h10, 32'h025C); chk("R10 released on disable", wdt_rst, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule